// File: doc/BRIEF.md
# Privileged Cycle Stamp Counter

This block keeps a free-running cycle count and hands it to the core on request. Software has two ways to ask for it. One is a dedicated stamp-read request. The other is a privileged register-read request, which names the counter by an address. Each request is allowed or refused according to the current operating mode, the current privilege level and a stamp-lock control bit.

An allowed request latches the whole count, taken in one cycle, into a pair of half-width result registers. A refused request leaves the result registers as they were and raises a one-cycle protection fault.

The count width is a parameter. The counter can be built either as one wide incrementer or as two halves joined by a carry.

Top module: `cyc_stamp_unit`

## Requirements
- R1: The count rises by exactly one on every clock edge after reset, so two stamp reads on consecutive cycles return values that differ by one.
- R2: While rst_n is low (asynchronous, active low), the counter, both result halves and gp_fault are zero. The first read after reset returns the number of clock edges since reset was released.
- R3: stamp_hi carries the upper half of the captured count and stamp_lo carries the lower half.
- R4: When mode_real is 1 (real mode), a stamp read (rd_stamp) is always allowed, whatever the values of priv and stamp_lock.
- R5: When mode_real is 0 and stamp_lock is 0, a stamp read is allowed at every priv value (0 to 3).
- R6: When mode_real is 0 and stamp_lock is 1, a stamp read is allowed only at priv 0. At any other priv it faults.
- R7: A register read (rd_reg) is allowed only at priv 0 or in real mode. In any other case it faults, whatever reg_addr holds.
- R8: An allowed register read latches the count only when reg_addr equals CTR_ADDR (default 32'h10). An allowed register read at any other address leaves the results unchanged and raises no fault.
- R9: A faulting read leaves stamp_hi and stamp_lo unchanged. It drives gp_fault high for the single cycle after the request, and gp_fault stays low when no refused request is present.
- R10: An allowed read updates the outputs at the clock edge that samples the request, with the count held in the cycle of the request. The outputs then hold that value until the next allowed read.
- R11: The counter wraps from all ones to zero with no indication, so a read in the cycle after the all-ones count returns zero.
- R12: When rd_stamp and rd_reg are both high, only the stamp-read rules decide the outcome, and rd_reg is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_real | input | 1 | 1 = real mode, 0 = protected or virtual mode |
| priv | input | PRIV_W | Current privilege level, where 0 is the most privileged |
| stamp_lock | input | 1 | When set, stamp reads outside real mode need priv 0 |
| rd_stamp | input | 1 | Stamp-read request, one per cycle it is high |
| rd_reg | input | 1 | Privileged register-read request |
| reg_addr | input | ADDR_W | Register address for rd_reg |
| stamp_hi | output | CNT_W/2 | Upper half of the last captured count |
| stamp_lo | output | CNT_W/2 | Lower half of the last captured count |
| gp_fault | output | 1 | One-cycle protection-fault pulse |

## Verification
Every result is due one edge after its request. The captured value, the unchanged value on a refusal and the fault pulse all appear at the clock edge that samples the request. The bench keeps its own count of edges since reset and takes the expected value at the falling edge where it raises a request, since that is the count the design holds in that cycle. It then compares the outputs at the next falling edge, and at the falling edge after that it confirms that the fault has dropped and the results have held.

// File: rtl/cyc_stamp_pkg.sv
package cyc_stamp_pkg;
   // Outcome of one request cycle, decided by the permission decoder
   typedef enum logic [1:0] {
      ACT_NONE  = 2'd0,
      ACT_TAKE  = 2'd1,
      ACT_FAULT = 2'd2
   } act_e;
endpackage

// File: rtl/cyc_stamp_ctr.sv
module cyc_stamp_ctr #(
   parameter int unsigned CNT_W     = 64,
   parameter bit          SPLIT_INC = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [CNT_W-1:0] cnt_o
);
   localparam int unsigned HALF_W = CNT_W / 2;

   generate
      if (SPLIT_INC) begin : g_split
         // Two half-width adders; upper half steps when the lower half is all ones
         logic [HALF_W-1:0] lo_q;
         logic [HALF_W-1:0] hi_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               lo_q <= '0;
               hi_q <= '0;
            end else begin
               lo_q <= lo_q + 1'b1;
               if (&lo_q) hi_q <= hi_q + 1'b1;
            end
         end
         assign cnt_o = {hi_q, lo_q};
      end else begin : g_flat
         logic [CNT_W-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cnt_q <= '0;
            else        cnt_q <= cnt_q + 1'b1;
         end
         assign cnt_o = cnt_q;
      end
   endgenerate
endmodule

// File: rtl/cyc_stamp_perm.sv
module cyc_stamp_perm
   import cyc_stamp_pkg::*;
#(
   parameter int unsigned          PRIV_W   = 2,
   parameter int unsigned          ADDR_W   = 32,
   parameter logic [ADDR_W-1:0]    CTR_ADDR = 'h10
) (
   input  logic              mode_real,
   input  logic [PRIV_W-1:0] priv,
   input  logic              stamp_lock,
   input  logic              rd_stamp,
   input  logic              rd_reg,
   input  logic [ADDR_W-1:0] reg_addr,
   output act_e              act
);
   localparam logic [PRIV_W-1:0] TOP_PRIV = '0;

   logic top_priv;
   logic stamp_ok;
   logic reg_ok;

   assign top_priv = (priv == TOP_PRIV);
   assign stamp_ok = mode_real | ~stamp_lock | top_priv;
   assign reg_ok   = mode_real | top_priv;

   always_comb begin
      act = ACT_NONE;
      if (rd_stamp) begin
         act = stamp_ok ? ACT_TAKE : ACT_FAULT;
      end else if (rd_reg) begin
         if (!reg_ok)                   act = ACT_FAULT;
         else if (reg_addr == CTR_ADDR) act = ACT_TAKE;
      end
   end
endmodule

// File: rtl/cyc_stamp_cap.sv
module cyc_stamp_cap
   import cyc_stamp_pkg::*;
#(
   parameter int unsigned CNT_W = 64
) (
   input  logic               clk,
   input  logic               rst_n,
   input  act_e               act,
   input  logic [CNT_W-1:0]   cnt,
   output logic [CNT_W/2-1:0] stamp_hi,
   output logic [CNT_W/2-1:0] stamp_lo,
   output logic               gp_fault
);
   localparam int unsigned HALF_W = CNT_W / 2;

   logic [CNT_W-1:0] snap_q;
   logic             flt_q;

   // One register holds both halves, so they always come from one sample
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         snap_q <= '0;
         flt_q  <= 1'b0;
      end else begin
         if (act == ACT_TAKE) snap_q <= cnt;
         flt_q <= (act == ACT_FAULT);
      end
   end

   assign stamp_hi = snap_q[CNT_W-1:HALF_W];
   assign stamp_lo = snap_q[HALF_W-1:0];
   assign gp_fault = flt_q;
endmodule

// File: rtl/cyc_stamp_unit.sv
module cyc_stamp_unit
   import cyc_stamp_pkg::*;
#(
   parameter int unsigned       CNT_W     = 64,
   parameter int unsigned       PRIV_W    = 2,
   parameter int unsigned       ADDR_W    = 32,
   parameter logic [ADDR_W-1:0] CTR_ADDR  = 'h10,
   parameter bit                SPLIT_INC = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               mode_real,
   input  logic [PRIV_W-1:0]  priv,
   input  logic               stamp_lock,
   input  logic               rd_stamp,
   input  logic               rd_reg,
   input  logic [ADDR_W-1:0]  reg_addr,
   output logic [CNT_W/2-1:0] stamp_hi,
   output logic [CNT_W/2-1:0] stamp_lo,
   output logic               gp_fault
);
   generate
      if (CNT_W < 2 || (CNT_W % 2) != 0) begin : g_bad_cnt_w
         $error("cyc_stamp_unit: CNT_W must be even and at least 2");
      end
      if (PRIV_W < 1 || ADDR_W < 1) begin : g_bad_w
         $error("cyc_stamp_unit: PRIV_W and ADDR_W must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_w;
   act_e             act_w;

   cyc_stamp_ctr #(.CNT_W(CNT_W), .SPLIT_INC(SPLIT_INC)) u_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .cnt_o (cnt_w)
   );

   cyc_stamp_perm #(.PRIV_W(PRIV_W), .ADDR_W(ADDR_W), .CTR_ADDR(CTR_ADDR)) u_perm (
      .mode_real  (mode_real),
      .priv       (priv),
      .stamp_lock (stamp_lock),
      .rd_stamp   (rd_stamp),
      .rd_reg     (rd_reg),
      .reg_addr   (reg_addr),
      .act        (act_w)
   );

   cyc_stamp_cap #(.CNT_W(CNT_W)) u_cap (
      .clk      (clk),
      .rst_n    (rst_n),
      .act      (act_w),
      .cnt      (cnt_w),
      .stamp_hi (stamp_hi),
      .stamp_lo (stamp_lo),
      .gp_fault (gp_fault)
   );
endmodule

// File: rtl/cyc_stamp_chk.sv
module cyc_stamp_chk #(
   parameter int unsigned       CNT_W    = 64,
   parameter int unsigned       PRIV_W   = 2,
   parameter int unsigned       ADDR_W   = 32,
   parameter logic [ADDR_W-1:0] CTR_ADDR = 'h10
) (
   input logic               clk,
   input logic               rst_n,
   input logic               mode_real,
   input logic [PRIV_W-1:0]  priv,
   input logic               stamp_lock,
   input logic               rd_stamp,
   input logic               rd_reg,
   input logic [ADDR_W-1:0]  reg_addr,
   input logic [CNT_W/2-1:0] stamp_hi,
   input logic [CNT_W/2-1:0] stamp_lo,
   input logic               gp_fault,
   input logic [CNT_W-1:0]   cnt
);
   logic sup;
   logic stamp_fine;
   logic reg_fine;
   assign sup        = (priv == '0);
   assign stamp_fine = mode_real || !stamp_lock || sup;
   assign reg_fine   = mode_real || sup;

   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> cnt == $past(cnt) + 1'b1);                          // R1

   AST_REAL_STAMP_OK: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stamp && mode_real) |=> !gp_fault);                               // R4

   AST_LOCK_DENY: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stamp && !mode_real && stamp_lock && !sup) |=> gp_fault);         // R6

   AST_REG_DENY: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_stamp && rd_reg && !reg_fine) |=> gp_fault);                     // R7

   AST_REG_MISS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_stamp && rd_reg && reg_fine && reg_addr != CTR_ADDR)
      |=> (!gp_fault && $stable({stamp_hi, stamp_lo})));                    // R8

   AST_FAULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      gp_fault |-> $stable({stamp_hi, stamp_lo}));                          // R9

   AST_FAULT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      gp_fault |-> $past(rd_stamp || rd_reg));                              // R9

   AST_STAMP_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stamp && stamp_fine) |=> {stamp_hi, stamp_lo} == $past(cnt));     // R10

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_stamp && !rd_reg) |=> ($stable({stamp_hi, stamp_lo}) && !gp_fault)); // R10
endmodule

bind cyc_stamp_unit cyc_stamp_chk #(
   .CNT_W(CNT_W), .PRIV_W(PRIV_W), .ADDR_W(ADDR_W), .CTR_ADDR(CTR_ADDR)
) u_chk (
   .clk(clk), .rst_n(rst_n), .mode_real(mode_real), .priv(priv),
   .stamp_lock(stamp_lock), .rd_stamp(rd_stamp), .rd_reg(rd_reg),
   .reg_addr(reg_addr), .stamp_hi(stamp_hi), .stamp_lo(stamp_lo),
   .gp_fault(gp_fault), .cnt(cnt_w)
);

// File: tb/sim_cyc_stamp_unit.sv
module sim_cyc_stamp_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mode_real = 1'b0;
   logic [1:0]  priv = 2'd0;
   logic        stamp_lock = 1'b0;
   logic        rd_stamp = 1'b0;
   logic        rd_reg = 1'b0;
   logic [31:0] reg_addr = 32'h0;
   logic [31:0] stamp_hi, stamp_lo;
   logic        gp_fault;
   logic        rd1 = 1'b0;
   logic [3:0]  hi1, lo1;
   logic        f1;

   int n_chk = 0;
   int n_fail = 0;
   logic [63:0] m;
   logic [63:0] held;

   always #10 clk = ~clk;   // 50 MHz

   // Edge count since reset release, kept apart from the design
   always @(posedge clk or negedge rst_n)
      if (!rst_n) m <= 64'd0;
      else        m <= m + 64'd1;

   cyc_stamp_unit u0 (
      .clk(clk), .rst_n(rst_n), .mode_real(mode_real), .priv(priv),
      .stamp_lock(stamp_lock), .rd_stamp(rd_stamp), .rd_reg(rd_reg),
      .reg_addr(reg_addr), .stamp_hi(stamp_hi), .stamp_lo(stamp_lo),
      .gp_fault(gp_fault)
   );

   // Narrow instance with split increment, used for wrap and half checks
   cyc_stamp_unit #(.CNT_W(8), .SPLIT_INC(1'b1)) u1 (
      .clk(clk), .rst_n(rst_n), .mode_real(1'b1), .priv(2'd3),
      .stamp_lock(1'b1), .rd_stamp(rd1), .rd_reg(1'b0),
      .reg_addr(32'h0), .stamp_hi(hi1), .stamp_lo(lo1), .gp_fault(f1)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Row: {mode_real, priv[1:0], stamp_lock, rd_stamp, rd_reg, addr_hit, take, fault}
   localparam int NROW = 13;
   localparam logic [8:0] ROWS [NROW] = '{
      9'b1_11_1_1_0_0_1_0,   // real, priv 3, locked, stamp read
      9'b0_11_0_1_0_0_1_0,   // prot, priv 3, unlocked
      9'b0_10_1_1_0_0_0_1,   // prot, priv 2, locked -> fault
      9'b0_00_1_1_0_0_1_0,   // prot, priv 0, locked
      9'b0_01_0_1_0_0_1_0,   // prot, priv 1, unlocked
      9'b0_00_0_0_1_1_1_0,   // reg read priv 0 at counter address
      9'b0_11_0_0_1_1_0_1,   // reg read priv 3 -> fault
      9'b1_10_0_0_1_1_1_0,   // reg read real mode priv 2
      9'b0_01_0_0_1_0_0_1,   // reg read priv 1 other address -> fault
      9'b0_00_0_0_1_0_0_0,   // reg read priv 0 other address -> nothing
      9'b0_11_0_1_1_1_1_0,   // both strobes, stamp rules allow
      9'b0_01_1_1_1_1_0_1,   // both strobes, stamp rules deny
      9'b1_00_0_1_0_0_1_0    // real, priv 0
   };

   function automatic string row_tag(input logic [8:0] r);
      if (r[4] && r[3]) return "R12";
      if (r[4]) return r[8] ? "R4" : (r[5] ? "R6" : "R5");
      if (r[2] || r[0]) return "R7";
      return "R8";
   endfunction

   task automatic run_row(input logic [8:0] r);
      logic [63:0] exp;
      string tag;
      tag = row_tag(r);
      @(negedge clk);
      mode_real  = r[8];
      priv       = r[7:6];
      stamp_lock = r[5];
      rd_stamp   = r[4];
      rd_reg     = r[3];
      reg_addr   = r[2] ? 32'h10 : 32'h11;
      exp = r[1] ? m : held;
      @(negedge clk);
      rd_stamp = 1'b0;
      rd_reg   = 1'b0;
      chk({stamp_hi, stamp_lo} == exp, {tag, " value R10"}, {stamp_hi, stamp_lo}, exp);
      chk(gp_fault == r[0], {tag, " fault"}, 64'(gp_fault), 64'(r[0]));
      held = exp;
      @(negedge clk);
      chk(gp_fault == 1'b0, "R9 pulse ends", 64'(gp_fault), 64'd0);
      chk({stamp_hi, stamp_lo} == held, "R9 R10 hold", {stamp_hi, stamp_lo}, held);
   endtask

   initial begin
      logic [63:0] e1, e2;
      int guard;
      held = 64'd0;
      repeat (3) @(negedge clk);
      chk({stamp_hi, stamp_lo} == 64'd0, "R2 reset value", {stamp_hi, stamp_lo}, 64'd0);
      chk(gp_fault == 1'b0, "R2 reset fault", 64'(gp_fault), 64'd0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      for (int i = 0; i < NROW; i++) run_row(ROWS[i]);

      // R1: back-to-back reads differ by one
      @(negedge clk);
      mode_real = 1'b1; rd_stamp = 1'b1; e1 = m;
      @(negedge clk);
      chk({stamp_hi, stamp_lo} == e1, "R1 first read", {stamp_hi, stamp_lo}, e1);
      e2 = m;
      @(negedge clk);
      rd_stamp = 1'b0;
      chk({stamp_hi, stamp_lo} == e2 && e2 == e1 + 64'd1, "R1 step",
          {stamp_hi, stamp_lo}, e1 + 64'd1);
      held = e2;

      // R2: reset in mid-run clears results, count restarts
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk({stamp_hi, stamp_lo} == 64'd0, "R2 mid-run reset", {stamp_hi, stamp_lo}, 64'd0);
      rst_n = 1'b1;
      held = 64'd0;
      repeat (4) @(negedge clk);
      rd_stamp = 1'b1; e1 = m;
      @(negedge clk);
      rd_stamp = 1'b0;
      chk({stamp_hi, stamp_lo} == 64'd4, "R2 restart count", {stamp_hi, stamp_lo}, 64'd4);
      chk(e1 == 64'd4, "R2 model count", e1, 64'd4);

      // R3: halves on the narrow instance
      guard = 0;
      while (m[7:0] != 8'h5A && guard < 300) begin @(negedge clk); guard++; end
      rd1 = 1'b1;
      @(negedge clk);
      rd1 = 1'b0;
      chk(hi1 == 4'h5, "R3 upper half", 64'(hi1), 64'h5);
      chk(lo1 == 4'hA, "R3 lower half", 64'(lo1), 64'hA);

      // R11: wrap from all ones to zero
      guard = 0;
      while (m[7:0] != 8'hFF && guard < 300) begin @(negedge clk); guard++; end
      rd1 = 1'b1;
      @(negedge clk);
      chk({hi1, lo1} == 8'hFF, "R11 all ones", 64'({hi1, lo1}), 64'hFF);
      @(negedge clk);
      rd1 = 1'b0;
      chk({hi1, lo1} == 8'h00, "R11 wrap to zero", 64'({hi1, lo1}), 64'h0);
      chk(f1 == 1'b0, "R11 no fault", 64'(f1), 64'd0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule